// File: doc/BRIEF.md
# Event Scaler Bank

This block holds ten event counters that sit behind a small register-access port. Each access carries a subaddress A and a function code F. Eight 16-bit counters count rising edges on eight coincidence inputs. A 24-bit trigger counter counts rising edges of the trigger input, but only while counting has been switched on. A 24-bit width counter adds one for every clock cycle in which the interrupt request level is high. Together these give rate figures and a measure of dead time.

Software reads the counters through the port. Each 24-bit counter is read as two words: a low word and a zero-padded high word. A counter can be cleared on its own, or all counters can be cleared with one command. A separate initialise input returns the whole block to its power-up state. Every command gets a response one cycle later. The response carries an accepted flag, a second flag that copies it, and the read data.

Top module: `evt_scaler_bank`

## Requirements
- R1: After reset, or one cycle after `init_z` is high, every counter reads zero and trigger counting is switched off.
- R2: Each coincidence input `coin_in[i]` passes through a two-stage synchroniser. Its counter adds exactly one for each low-to-high transition, however long the input stays high. F=2 A=i reads counter i, for i=0..7.
- R3: The 16-bit counters wrap from 0xFFFF to 0. The 24-bit counters wrap from 0xFFFFFF to 0.
- R4: The width counter adds one for each clock cycle in which `irq_pending` is high. F=2 A=12 returns its bits 15..0. F=2 A=13 returns its high part.
- R5: The trigger counter counts synchronised rising edges of `trig_in` only while counting is switched on. F=26 A=0 switches counting on and F=24 A=0 switches it off. F=2 A=14 returns bits 15..0 and F=2 A=15 returns the high part.
- R6: A high-part read (A=13 or A=15) puts counter bits 23..16 on `rsp_data[7:0]`. It returns `rsp_data[15:8]` as zero.
- R7: F=11 with A=0..7, A=12 or A=14 clears only the addressed counter and leaves every other counter unchanged.
- R8: F=11 with A=15 clears all ten counters.
- R9: When a clear and a count increment fall in the same cycle, the counter ends at zero.
- R10: `rsp_x` and `rsp_q` are high for the commands F=2 with A=0..7 or 12..15, F=11 with A=0..7, 12, 14 or 15, and F=24 or F=26 with A=0. For any other command both flags are low, `rsp_data` is zero, and no counter or enable changes.
- R11: The response (`rsp_valid`, flags, data) appears in the cycle after the one in which `cmd_valid` was sampled. Read data is the counter value in the cycle the command was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| init_z | input | 1 | Synchronous module initialise |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_f | input | 5 | Function code |
| cmd_a | input | 4 | Subaddress |
| coin_in | input | 8 | Coincidence signals to count |
| trig_in | input | 1 | Logic trigger signal |
| irq_pending | input | 1 | Interrupt request level, synchronous |
| rsp_valid | output | 1 | Response present |
| rsp_x | output | 1 | Command accepted |
| rsp_q | output | 1 | Command response flag |
| rsp_data | output | 16 | Read data |

## Verification
The hardest states to reach are counter wrap and non-zero high words. Both need more than 65535 events. The stimulus toggles every counting input on every clock for 131078 cycles while holding the request level high. This carries all ten counters past the 16-bit boundary in one pass, and the bench then reads both halves of each counter. Clear-versus-count collisions need the clear command to land exactly on the cycle in which a synchronised edge arrives. The stimulus therefore raises an input and issues the clear on the second falling edge after it.

// File: rtl/evt_scaler_bank.sv
module evt_scaler_bank #(
  parameter int NARROW_W    = 16,
  parameter int WIDE_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_z,
  input  logic                cmd_valid,
  input  logic [4:0]          cmd_f,
  input  logic [3:0]          cmd_a,
  input  logic [7:0]          coin_in,
  input  logic                trig_in,
  input  logic                irq_pending,
  output logic                rsp_valid,
  output logic                rsp_x,
  output logic                rsp_q,
  output logic [NARROW_W-1:0] rsp_data
);
  localparam int N_COIN = 8;
  localparam int HI_W   = WIDE_W - NARROW_W;

  logic [N_COIN:0]     stg [SYNC_STAGES+1];
  logic [N_COIN:0]     rise;
  logic [NARROW_W-1:0] cnt_n [N_COIN];
  logic [WIDE_W-1:0]   irq_cnt, trg_cnt;
  logic                trig_en;
  logic [N_COIN-1:0]   clr_n;
  logic [NARROW_W-1:0] rd_mux;

  wire f_rd   = cmd_f == 5'd2;
  wire f_clr  = cmd_f == 5'd11;
  wire f_on   = cmd_f == 5'd26 && cmd_a == 4'd0;
  wire f_off  = cmd_f == 5'd24 && cmd_a == 4'd0;
  wire a_lo   = ~cmd_a[3];
  wire rd_ok  = f_rd && (a_lo || cmd_a >= 4'd12);
  wire clr_ok = f_clr && (a_lo || cmd_a == 4'd12 || cmd_a == 4'd14 || cmd_a == 4'd15);
  wire impl   = cmd_valid && (rd_ok || clr_ok || f_on || f_off);
  wire clr_cmd = cmd_valid && f_clr;
  wire clr_all = init_z || (clr_cmd && cmd_a == 4'd15);
  wire clr_irq = clr_all || (clr_cmd && cmd_a == 4'd12);
  wire clr_trg = clr_all || (clr_cmd && cmd_a == 4'd14);

  assign rise = stg[SYNC_STAGES-1] & ~stg[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= SYNC_STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= {trig_in, coin_in};
      for (int s = 1; s <= SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  always_comb begin
    for (int i = 0; i < N_COIN; i++)
      clr_n[i] = clr_all || (clr_cmd && cmd_a == 4'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_COIN; i++) cnt_n[i] <= '0;
    end else begin
      for (int i = 0; i < N_COIN; i++)
        if (clr_n[i])     cnt_n[i] <= '0;
        else if (rise[i]) cnt_n[i] <= cnt_n[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cnt <= '0;
      trg_cnt <= '0;
      trig_en <= 1'b0;
    end else begin
      if (clr_irq)          irq_cnt <= '0;
      else if (irq_pending) irq_cnt <= irq_cnt + 1'b1;
      if (clr_trg)                         trg_cnt <= '0;
      else if (trig_en && rise[N_COIN])    trg_cnt <= trg_cnt + 1'b1;
      if (init_z)                     trig_en <= 1'b0;
      else if (cmd_valid && f_on)     trig_en <= 1'b1;
      else if (cmd_valid && f_off)    trig_en <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (a_lo) rd_mux = cnt_n[cmd_a[2:0]];
    else case (cmd_a)
      4'd12:   rd_mux = irq_cnt[NARROW_W-1:0];
      4'd13:   rd_mux = {{(NARROW_W-HI_W){1'b0}}, irq_cnt[WIDE_W-1:NARROW_W]};
      4'd14:   rd_mux = trg_cnt[NARROW_W-1:0];
      4'd15:   rd_mux = {{(NARROW_W-HI_W){1'b0}}, trg_cnt[WIDE_W-1:NARROW_W]};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_x     <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_x     <= impl;
      rsp_q     <= impl;
      rsp_data  <= (cmd_valid && rd_ok) ? rd_mux : '0;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(cmd_valid)); // R11
  AST_HIGH_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && f_rd && (cmd_a == 4'd13 || cmd_a == 4'd15)) |-> rsp_data[NARROW_W-1:HI_W] == '0); // R6
  AST_UNIMPL_NO_X: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(f_rd || f_clr || cmd_f == 5'd24 || cmd_f == 5'd26)) |=> !rsp_x && rsp_data == '0); // R10
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && f_clr && cmd_a == 4'd15) |=> (irq_cnt == '0 && trg_cnt == '0 && cnt_n[0] == '0 && cnt_n[7] == '0)); // R8
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && f_clr && cmd_a == 4'd0) |=> cnt_n[0] == '0); // R9
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> (trg_cnt == $past(trg_cnt) || trg_cnt == '0)); // R5
  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_n[0] != $past(cnt_n[0])) |-> (cnt_n[0] == NARROW_W'($past(cnt_n[0]) + 1'b1) || cnt_n[0] == '0)); // R3
endmodule

// File: tb/test_evt_scaler_bank.sv
module test_evt_scaler_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_z = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_f = '0;
  logic [3:0]  cmd_a = '0;
  logic [7:0]  coin_in = '0;
  logic        trig_in = 1'b0;
  logic        irq_pending = 1'b0;
  logic        rsp_valid, rsp_x, rsp_q;
  logic [15:0] rsp_data;

  int checks = 0;
  int errors = 0;

  typedef struct { logic x; logic [15:0] d; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  evt_scaler_bank i_evt_scaler_bank (
    .clk(clk), .rst_n(rst_n), .init_z(init_z), .cmd_valid(cmd_valid),
    .cmd_f(cmd_f), .cmd_a(cmd_a), .coin_in(coin_in), .trig_in(trig_in),
    .irq_pending(irq_pending), .rsp_valid(rsp_valid), .rsp_x(rsp_x),
    .rsp_q(rsp_q), .rsp_data(rsp_data)
  );

  task automatic cmd(input logic [4:0] f, input logic [3:0] a,
                     input logic ex, input logic [15:0] ed, input string tag);
    exp_t e;
    @(negedge clk);
    cmd_f = f; cmd_a = a; cmd_valid = 1'b1;
    e.x = ex; e.d = ed; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_coin(input int ch);
    coin_in[ch] = 1'b1; idle(3);
    coin_in[ch] = 1'b0; idle(3);
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1; idle(3);
    trig_in = 1'b0; idle(3);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: x=%0b data=%h expected none", rsp_x, rsp_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_x !== e.x || rsp_q !== e.x || rsp_data !== e.d) begin
          errors++;
          $display("FAIL %s: x=%0b q=%0b data=%h expected x=%0b data=%h",
                   e.tag, rsp_x, rsp_q, rsp_data, e.x, e.d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    for (int a = 0; a < 16; a++)
      if (a < 8 || a >= 12) cmd(5'd2, 4'(a), 1'b1, 16'h0, "R1 reset value");

    for (int ch = 0; ch < 8; ch++)
      for (int k = 0; k <= ch; k++) pulse_coin(ch);
    idle(4);
    for (int ch = 0; ch < 8; ch++) cmd(5'd2, 4'(ch), 1'b1, 16'(ch + 1), "R2 edge count");

    irq_pending = 1'b1; idle(37); irq_pending = 1'b0; idle(2);
    cmd(5'd2, 4'd12, 1'b1, 16'd37, "R4 width low");
    cmd(5'd2, 4'd13, 1'b1, 16'd0,  "R4 width high");

    repeat (3) pulse_trig();
    idle(4);
    cmd(5'd2, 4'd14, 1'b1, 16'd0, "R5 disabled trigger");
    cmd(5'd26, 4'd0, 1'b1, 16'd0, "R5 enable");
    repeat (5) pulse_trig();
    idle(4);
    cmd(5'd2, 4'd14, 1'b1, 16'd5, "R5 enabled trigger");
    cmd(5'd24, 4'd0, 1'b1, 16'd0, "R5 disable");
    repeat (2) pulse_trig();
    idle(4);
    cmd(5'd2, 4'd14, 1'b1, 16'd5, "R5 gated after disable");
    cmd(5'd2, 4'd15, 1'b1, 16'd0, "R5 trigger high");

    cmd(5'd26, 4'd1, 1'b0, 16'd0, "R10 unimpl enable A1");
    pulse_trig(); idle(4);
    cmd(5'd2, 4'd14, 1'b1, 16'd5, "R10 enable unchanged");
    cmd(5'd11, 4'd8, 1'b0, 16'd0, "R10 unimpl clear A8");
    cmd(5'd2, 4'd0, 1'b1, 16'd1, "R10 counter kept");
    cmd(5'd2, 4'd9, 1'b0, 16'd0, "R10 unimpl read A9");
    cmd(5'd5, 4'd0, 1'b0, 16'd0, "R10 unimpl function");

    cmd(5'd11, 4'd1, 1'b1, 16'd0, "R7 clear ch1");
    cmd(5'd2, 4'd1, 1'b1, 16'd0, "R7 ch1 cleared");
    cmd(5'd2, 4'd0, 1'b1, 16'd1, "R7 ch0 kept");
    cmd(5'd2, 4'd2, 1'b1, 16'd3, "R7 ch2 kept");
    cmd(5'd11, 4'd12, 1'b1, 16'd0, "R7 clear width");
    cmd(5'd2, 4'd12, 1'b1, 16'd0, "R7 width cleared");
    cmd(5'd2, 4'd14, 1'b1, 16'd5, "R7 trigger kept");
    cmd(5'd11, 4'd14, 1'b1, 16'd0, "R7 clear trigger");
    cmd(5'd2, 4'd14, 1'b1, 16'd0, "R7 trigger cleared");
    cmd(5'd2, 4'd3, 1'b1, 16'd4, "R7 ch3 kept");

    @(negedge clk); coin_in[0] = 1'b1;
    @(negedge clk);
    cmd(5'd11, 4'd0, 1'b1, 16'd0, "R9 clear at edge");
    idle(3); coin_in[0] = 1'b0; idle(3);
    cmd(5'd2, 4'd0, 1'b1, 16'd0, "R9 clear wins");
    pulse_coin(0); idle(3);
    cmd(5'd2, 4'd0, 1'b1, 16'd1, "R9 counts after");

    cmd(5'd11, 4'd15, 1'b1, 16'd0, "R8 clear all");
    for (int a = 0; a < 16; a++)
      if (a < 8 || a >= 12) cmd(5'd2, 4'(a), 1'b1, 16'h0, "R8 all cleared");

    cmd(5'd26, 4'd0, 1'b1, 16'd0, "R5 enable for wrap");
    for (int k = 0; k < 2 * 65539; k++) begin
      @(negedge clk);
      coin_in = ~coin_in;
      trig_in = ~trig_in;
      if (k == 0) irq_pending = 1'b1;
    end
    @(negedge clk); irq_pending = 1'b0;
    idle(5);
    for (int ch = 0; ch < 8; ch++) cmd(5'd2, 4'(ch), 1'b1, 16'd3, "R3 narrow wrap");
    cmd(5'd2, 4'd12, 1'b1, 16'h0006, "R6 width low");
    cmd(5'd2, 4'd13, 1'b1, 16'h0002, "R6 width high");
    cmd(5'd2, 4'd14, 1'b1, 16'h0003, "R6 trigger low");
    cmd(5'd2, 4'd15, 1'b1, 16'h0001, "R6 trigger high");

    @(negedge clk); init_z = 1'b1;
    @(negedge clk); init_z = 1'b0;
    cmd(5'd2, 4'd0, 1'b1, 16'd0, "R1 init clears ch0");
    cmd(5'd2, 4'd13, 1'b1, 16'd0, "R1 init clears width");
    cmd(5'd2, 4'd15, 1'b1, 16'd0, "R1 init clears trigger");
    pulse_trig(); idle(4);
    cmd(5'd2, 4'd14, 1'b1, 16'd0, "R1 init disables trigger");

    idle(3);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses: %0d pending, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule